// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is an 8192-bit on-chip memory with one write port and one read port. Each port has its own data width, chosen from 1, 2, 4, 8, 16 or 32 bits, and any pairing of those widths is allowed. Both ports see the same linear bit space. A port of width W at address A covers bits A*W up to A*W+W-1. A wide write therefore appears as several consecutive narrow reads, and the lowest narrow address holds the least significant bits.

The write port has a data input, an address, a write enable, a byte-lane enable and a clock enable. The read port has an address, a read enable and a clock enable, and it returns data on `rd_q`. Each port also has an address-stall input. While that input is high, the port keeps using the address it last captured and ignores the address pins. A parameter picks the clock arrangement: either one shared clock (taken from `wr_clk`) or independent write and read clocks. A second parameter adds an extra output register that delays read data by one more read-clock cycle. An asynchronous clear returns the output registers and both captured addresses to zero and leaves the stored contents untouched.

Top module: `msdp_ram`

## Requirements
- R1: A port of width W at address A maps to bits A*W through A*W+W-1 of one 8192-bit space, with lower addresses holding lower bits. Each width is one of 1, 2, 4, 8, 16 or 32, and each port's address width is log2(8192/W).
- R2: With the direct output mode, a read sampled at a read-clock edge shows on `rd_q` right after that edge. With the piped mode it shows one read-clock edge later, and `rd_q` keeps its previous value after the first edge.
- R3: A read-clock edge at which `rd_en` is low leaves the read data unchanged, whatever the read address does.
- R4: Byte lane i of the write data is bits 8i+7..8i and is enabled by `wr_be[i]`; lanes whose enable is low keep their old contents. For a write width below 8, the single bit `wr_be[0]` gates the whole write.
- R5: While `wr_stall` is high, writes go to the write address captured at the last write-clock edge where `wr_stall` was low and `wr_ce` was high.
- R6: While `rd_stall` is high, reads use the read address captured at the last read-clock edge where `rd_stall` was low and `rd_ce` was high.
- R7: With `wr_ce` low, an edge writes nothing. With `rd_ce` low, an edge changes neither the read data nor the output register.
- R8: A write and a read in the same cycle to different locations both complete. On a shared clock, a read of bits that the same edge writes returns the old contents.
- R9: While `clr` is high, `rd_q` and both captured addresses are zero, taking effect without a clock edge. The stored contents are kept.
- R10: An edge with `wr_en` low leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; also the read clock in shared mode |
| rd_clk | input | 1 | Read clock in split mode; unused in shared mode |
| clr | input | 1 | Asynchronous clear of output registers and captured addresses, active high |
| wr_data | input | WR_W | Write data |
| wr_addr | input | log2(8192/WR_W) | Write address in units of WR_W bits |
| wr_en | input | 1 | Write request |
| wr_be | input | max(1, WR_W/8) | Byte-lane enables |
| wr_stall | input | 1 | Hold the captured write address |
| wr_ce | input | 1 | Write-side clock enable |
| rd_addr | input | log2(8192/RD_W) | Read address in units of RD_W bits |
| rd_en | input | 1 | Read request |
| rd_stall | input | 1 | Hold the captured read address |
| rd_ce | input | 1 | Read-side clock enable |
| rd_q | output | RD_W | Read data |

## Verification
A write takes effect at the first write-clock edge after its inputs are set. In direct mode, read data is due one read-clock edge after the read request. In piped mode it is due two edges later, and `rd_q` must still show the previous value after the first edge. The clear acts within the same cycle. The bench changes inputs on falling edges and reads `rd_q` on the falling edge that follows the required number of rising edges. For the piped instance it samples after both the first and the second edge. The clear is checked a few time units after it rises, with no clock edge in between.

// File: rtl/msdp_pkg.sv
package msdp_pkg;

    localparam int TOTAL_BITS = 8192;

    typedef enum logic {
        OUT_DIRECT = 1'b0,
        OUT_PIPED  = 1'b1
    } out_mode_e;

    typedef enum logic {
        CLK_SHARED = 1'b0,
        CLK_SPLIT  = 1'b1
    } clk_mode_e;

    function automatic int lanes_of(int w);
        return (w >= 8) ? w / 8 : 1;
    endfunction

    function automatic int addr_bits(int w);
        return $clog2(TOTAL_BITS / w);
    endfunction

    function automatic int wider(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/msdp_addr_hold.sv
module msdp_addr_hold #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          ce,
    input  logic          stall,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_eff
);
    logic [AW-1:0] held;

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            held <= '0;
        else if (ce && !stall)
            held <= addr_in;
    end

    assign addr_eff = stall ? held : addr_in;
endmodule

// File: rtl/msdp_wr_map.sv
module msdp_wr_map import msdp_pkg::*; #(
    parameter  int WR_W = 32,
    parameter  int WIDE = 32,
    localparam int WA_W = addr_bits(WR_W),
    localparam int BE_W = lanes_of(WR_W),
    localparam int DL   = addr_bits(WIDE)
) (
    input  logic [WA_W-1:0] addr_eff,
    input  logic [WR_W-1:0] data,
    input  logic [BE_W-1:0] be,
    output logic [DL-1:0]   widx,
    output logic [WIDE-1:0] wmask,
    output logic [WIDE-1:0] wdata
);
    localparam int unsigned SUB = WIDE / WR_W;

    int unsigned   a_i;
    int unsigned   sub_i;
    logic [WR_W-1:0] lane_bits;

    always_comb begin
        for (int k = 0; k < WR_W; k++)
            lane_bits[k] = be[k / 8];
        a_i   = 32'(addr_eff);
        sub_i = a_i % SUB;
        widx  = DL'(a_i / SUB);
        wmask = WIDE'(lane_bits) << (sub_i * WR_W);
        wdata = WIDE'(data) << (sub_i * WR_W);
    end
endmodule

// File: rtl/msdp_store.sv
module msdp_store #(
    parameter int WIDE = 32,
    parameter int DL   = 8
) (
    input  logic            wclk,
    input  logic            we,
    input  logic [DL-1:0]   widx,
    input  logic [WIDE-1:0] wmask,
    input  logic [WIDE-1:0] wdata,
    input  logic [DL-1:0]   ridx,
    output logic [WIDE-1:0] rword
);
    localparam int DEPTH = 2 ** DL;

    logic [WIDE-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we)
            mem[widx] <= (mem[widx] & ~wmask) | (wdata & wmask);
    end

    assign rword = mem[ridx];
endmodule

// File: rtl/msdp_rd_port.sv
module msdp_rd_port import msdp_pkg::*; #(
    parameter  int        RD_W     = 8,
    parameter  int        WIDE     = 32,
    parameter  out_mode_e OUT_MODE = OUT_DIRECT,
    localparam int        RA_W     = addr_bits(RD_W),
    localparam int        DL       = addr_bits(WIDE)
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            en,
    input  logic            ce,
    input  logic [RA_W-1:0] addr_eff,
    input  logic [WIDE-1:0] rword,
    output logic [DL-1:0]   ridx,
    output logic [RD_W-1:0] stage1,
    output logic [RD_W-1:0] q
);
    localparam int unsigned SUB = WIDE / RD_W;

    int unsigned     a_i;
    int unsigned     sub_i;
    logic [WIDE-1:0] shifted;
    logic [RD_W-1:0] slice;

    always_comb begin
        a_i     = 32'(addr_eff);
        sub_i   = a_i % SUB;
        ridx    = DL'(a_i / SUB);
        shifted = rword >> (sub_i * RD_W);
        slice   = RD_W'(shifted);
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            stage1 <= '0;
        else if (en && ce)
            stage1 <= slice;
    end

    generate
        if (OUT_MODE == OUT_PIPED) begin : g_piped
            logic [RD_W-1:0] q_r;
            always_ff @(posedge clk or posedge clr) begin
                if (clr)
                    q_r <= '0;
                else if (ce)
                    q_r <= stage1;
            end
            assign q = q_r;
        end else begin : g_direct
            assign q = stage1;
        end
    endgenerate
endmodule

// File: rtl/msdp_ram.sv
module msdp_ram import msdp_pkg::*; #(
    parameter  int        WR_W     = 32,
    parameter  int        RD_W     = 8,
    parameter  out_mode_e OUT_MODE = OUT_DIRECT,
    parameter  clk_mode_e CLK_MODE = CLK_SHARED,
    localparam int        WA_W     = addr_bits(WR_W),
    localparam int        RA_W     = addr_bits(RD_W),
    localparam int        BE_W     = lanes_of(WR_W)
) (
    input  logic            wr_clk,
    input  logic            rd_clk,
    input  logic            clr,
    input  logic [WR_W-1:0] wr_data,
    input  logic [WA_W-1:0] wr_addr,
    input  logic            wr_en,
    input  logic [BE_W-1:0] wr_be,
    input  logic            wr_stall,
    input  logic            wr_ce,
    input  logic [RA_W-1:0] rd_addr,
    input  logic            rd_en,
    input  logic            rd_stall,
    input  logic            rd_ce,
    output logic [RD_W-1:0] rd_q
);
    localparam int WIDE = wider(WR_W, RD_W);
    localparam int DL   = addr_bits(WIDE);

    logic            rclk;
    logic [WA_W-1:0] wr_eff;
    logic [RA_W-1:0] rd_eff;
    logic [DL-1:0]   widx;
    logic [DL-1:0]   ridx;
    logic [WIDE-1:0] wmask;
    logic [WIDE-1:0] wdata;
    logic [WIDE-1:0] rword;
    logic [RD_W-1:0] stage1;
    logic            wr_fire;

    generate
        if (CLK_MODE == CLK_SPLIT) begin : g_split
            assign rclk = rd_clk;
        end else begin : g_shared
            logic unused_rd_clk;
            assign unused_rd_clk = rd_clk;
            assign rclk          = wr_clk;
        end
    endgenerate

    assign wr_fire = wr_en && wr_ce;

    msdp_addr_hold #(.AW(WA_W)) u_wr_hold (
        .clk      (wr_clk),
        .clr      (clr),
        .ce       (wr_ce),
        .stall    (wr_stall),
        .addr_in  (wr_addr),
        .addr_eff (wr_eff)
    );

    msdp_addr_hold #(.AW(RA_W)) u_rd_hold (
        .clk      (rclk),
        .clr      (clr),
        .ce       (rd_ce),
        .stall    (rd_stall),
        .addr_in  (rd_addr),
        .addr_eff (rd_eff)
    );

    msdp_wr_map #(.WR_W(WR_W), .WIDE(WIDE)) u_wr_map (
        .addr_eff (wr_eff),
        .data     (wr_data),
        .be       (wr_be),
        .widx     (widx),
        .wmask    (wmask),
        .wdata    (wdata)
    );

    msdp_store #(.WIDE(WIDE), .DL(DL)) u_store (
        .wclk  (wr_clk),
        .we    (wr_fire),
        .widx  (widx),
        .wmask (wmask),
        .wdata (wdata),
        .ridx  (ridx),
        .rword (rword)
    );

    msdp_rd_port #(.RD_W(RD_W), .WIDE(WIDE), .OUT_MODE(OUT_MODE)) u_rd_port (
        .clk      (rclk),
        .clr      (clr),
        .en       (rd_en),
        .ce       (rd_ce),
        .addr_eff (rd_eff),
        .rword    (rword),
        .ridx     (ridx),
        .stage1   (stage1),
        .q        (rd_q)
    );
endmodule

// File: rtl/msdp_ram_chk.sv
module msdp_ram_chk import msdp_pkg::*; #(
    parameter int        RD_W     = 8,
    parameter int        WA_W     = 8,
    parameter int        RA_W     = 10,
    parameter out_mode_e OUT_MODE = OUT_DIRECT
) (
    input logic            wclk,
    input logic            rclk,
    input logic            clr,
    input logic            wr_ce,
    input logic            wr_stall,
    input logic [WA_W-1:0] wr_addr,
    input logic [WA_W-1:0] wr_eff,
    input logic            rd_en,
    input logic            rd_ce,
    input logic            rd_stall,
    input logic [RA_W-1:0] rd_addr,
    input logic [RA_W-1:0] rd_eff,
    input logic [RD_W-1:0] stage1,
    input logic [RD_W-1:0] rd_q
);
    assert_wstall_keep_R5: assert property (@(posedge wclk) disable iff (clr)
        (wr_stall && $past(wr_stall)) |-> wr_eff == $past(wr_eff));

    assert_wstall_take_R5: assert property (@(posedge wclk) disable iff (clr)
        (wr_stall && $past(wr_ce && !wr_stall && !clr)) |-> wr_eff == $past(wr_addr));

    assert_rstall_keep_R6: assert property (@(posedge rclk) disable iff (clr)
        (rd_stall && $past(rd_stall)) |-> rd_eff == $past(rd_eff));

    assert_rstall_take_R6: assert property (@(posedge rclk) disable iff (clr)
        (rd_stall && $past(rd_ce && !rd_stall && !clr)) |-> rd_eff == $past(rd_addr));

    assert_read_hold_R3: assert property (@(posedge rclk) disable iff (clr)
        !(rd_en && rd_ce) |=> $stable(stage1));

    assert_clear_out_R9: assert property (@(posedge rclk) disable iff (clr)
        $fell(clr) |-> rd_q == '0);

    generate
        if (OUT_MODE == OUT_PIPED) begin : g_piped_chk
            assert_pipe_delay_R2: assert property (@(posedge rclk) disable iff (clr)
                rd_ce |=> rd_q == $past(stage1));

            assert_ce_hold_R7: assert property (@(posedge rclk) disable iff (clr)
                !rd_ce |=> $stable(rd_q));
        end
    endgenerate
endmodule

bind msdp_ram msdp_ram_chk #(
    .RD_W     (RD_W),
    .WA_W     (WA_W),
    .RA_W     (RA_W),
    .OUT_MODE (OUT_MODE)
) u_chk (
    .wclk     (wr_clk),
    .rclk     (rclk),
    .clr      (clr),
    .wr_ce    (wr_ce),
    .wr_stall (wr_stall),
    .wr_addr  (wr_addr),
    .wr_eff   (wr_eff),
    .rd_en    (rd_en),
    .rd_ce    (rd_ce),
    .rd_stall (rd_stall),
    .rd_addr  (rd_addr),
    .rd_eff   (rd_eff),
    .stage1   (stage1),
    .rd_q     (rd_q)
);

// File: tb/test_msdp_ram.sv
module test_msdp_ram;
    import msdp_pkg::*;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic clr;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    logic [8191:0] ref_a;
    logic [8191:0] ref_b;

    // instance A: 32-bit write, 8-bit read, direct output, shared clock
    logic [31:0] a_wd;
    logic [7:0]  a_wa;
    logic        a_we, a_ws, a_wce;
    logic [3:0]  a_be;
    logic [9:0]  a_ra;
    logic        a_re, a_rs, a_rce;
    logic [7:0]  a_q;

    // instance B: 4-bit write, 16-bit read, piped output, split clocks
    logic [3:0]  b_wd;
    logic [10:0] b_wa;
    logic        b_we, b_ws, b_wce;
    logic [0:0]  b_be;
    logic [8:0]  b_ra;
    logic        b_re, b_rs, b_rce;
    logic [15:0] b_q;

    always #(CLK_P / 2) clk = ~clk;

    msdp_ram #(.WR_W(32), .RD_W(8), .OUT_MODE(OUT_DIRECT), .CLK_MODE(CLK_SHARED)) i_msdp_ram (
        .wr_clk(clk), .rd_clk(clk), .clr(clr),
        .wr_data(a_wd), .wr_addr(a_wa), .wr_en(a_we), .wr_be(a_be),
        .wr_stall(a_ws), .wr_ce(a_wce),
        .rd_addr(a_ra), .rd_en(a_re), .rd_stall(a_rs), .rd_ce(a_rce), .rd_q(a_q)
    );

    msdp_ram #(.WR_W(4), .RD_W(16), .OUT_MODE(OUT_PIPED), .CLK_MODE(CLK_SPLIT)) i_msdp_ram_b (
        .wr_clk(clk), .rd_clk(clk), .clr(clr),
        .wr_data(b_wd), .wr_addr(b_wa), .wr_en(b_we), .wr_be(b_be),
        .wr_stall(b_ws), .wr_ce(b_wce),
        .rd_addr(b_ra), .rd_en(b_re), .rd_stall(b_rs), .rd_ce(b_rce), .rd_q(b_q)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic a_write(input logic [7:0] ad, input logic [31:0] d, input logic [3:0] be);
        a_wa = ad; a_wd = d; a_be = be; a_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0;
        for (int k = 0; k < 32; k++)
            if (be[k / 8]) ref_a[32 * int'(ad) + k] = d[k];
    endtask

    task automatic a_read(input logic [9:0] ad, input string req);
        a_ra = ad; a_re = 1'b1;
        @(negedge clk);
        a_re = 1'b0;
        check(32'(a_q), 32'(ref_a[8 * int'(ad) +: 8]), req);
    endtask

    task automatic b_write(input logic [10:0] ad, input logic [3:0] d, input logic be);
        b_wa = ad; b_wd = d; b_be = be; b_we = 1'b1;
        @(negedge clk);
        b_we = 1'b0;
        if (be)
            for (int k = 0; k < 4; k++) ref_b[4 * int'(ad) + k] = d[k];
    endtask

    task automatic b_read(input logic [8:0] ad, input string req);
        logic [15:0] prev;
        prev = b_q;
        b_ra = ad; b_re = 1'b1;
        @(negedge clk);
        b_re = 1'b0;
        check(32'(b_q), 32'(prev), {req, " R2 first edge keeps old"});
        @(negedge clk);
        check(32'(b_q), 32'(ref_b[16 * int'(ad) +: 16]), {req, " R2 second edge"});
    endtask

    task automatic t_reset;
        check(32'(a_q), 32'h0, "R9 reset value A");
        check(32'(b_q), 32'h0, "R9 reset value B");
    endtask

    task automatic t_map;
        a_write(8'd0, 32'hA1B2C3D4, 4'hF);
        a_write(8'd1, 32'h0F1E2D3C, 4'hF);
        a_write(8'd2, $urandom, 4'hF);
        a_write(8'd3, $urandom, 4'hF);
        for (int i = 0; i < 16; i++) a_read(10'(i), "R1 wide write, narrow reads");
    endtask

    task automatic t_be;
        a_write(8'd6, 32'hFFFFFFFF, 4'hF);
        a_write(8'd6, 32'h12345678, 4'b0101);
        for (int i = 24; i < 28; i++) a_read(10'(i), "R4 byte lanes");
        check(32'(ref_a[6 * 32 +: 32]), 32'hFF34FF78, "R4 model lane pattern");
    endtask

    task automatic t_wstall;
        a_write(8'd9, 32'h11111111, 4'hF);
        a_write(8'd5, 32'hCAFEF00D, 4'hF);
        a_wa = 8'd9; a_wd = 32'h5A5AA5A5; a_be = 4'hF; a_ws = 1'b1; a_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0; a_ws = 1'b0;
        ref_a[5 * 32 +: 32] = 32'h5A5AA5A5;
        for (int i = 20; i < 24; i++) a_read(10'(i), "R5 stalled write lands on held address");
        a_read(10'd36, "R5 stalled address pins ignored");
    endtask

    task automatic t_rstall;
        a_read(10'd3, "R6 capture read address");
        a_ra = 10'd7; a_rs = 1'b1; a_re = 1'b1;
        @(negedge clk);
        a_re = 1'b0; a_rs = 1'b0;
        check(32'(a_q), 32'(ref_a[3 * 8 +: 8]), "R6 stalled read uses held address");
    endtask

    task automatic t_enables;
        a_wa = 8'd6; a_wd = 32'h0; a_be = 4'hF; a_we = 1'b1; a_wce = 1'b0;
        @(negedge clk);
        a_we = 1'b0; a_wce = 1'b1;
        a_read(10'd24, "R7 write clock enable low");
        a_wd = 32'h0; a_we = 1'b0;
        @(negedge clk);
        a_read(10'd25, "R10 write enable low");
        a_read(10'd24, "R7 prime read");
        a_ra = 10'd25; a_re = 1'b1; a_rce = 1'b0;
        @(negedge clk);
        a_re = 1'b0; a_rce = 1'b1;
        check(32'(a_q), 32'h78, "R7 read clock enable low holds");
        a_ra = 10'd26;
        @(negedge clk);
        @(negedge clk);
        check(32'(a_q), 32'h78, "R3 read enable low holds");
    endtask

    task automatic t_same;
        logic [7:0] exp_old;
        a_write(8'd10, 32'h01020304, 4'hF);
        exp_old = ref_a[40 * 8 +: 8];
        a_wa = 8'd10; a_wd = 32'hF0E0D0C0; a_be = 4'hF; a_we = 1'b1;
        a_ra = 10'd40; a_re = 1'b1;
        @(negedge clk);
        a_we = 1'b0; a_re = 1'b0;
        ref_a[10 * 32 +: 32] = 32'hF0E0D0C0;
        check(32'(a_q), 32'(exp_old), "R8 same bits read old");
        a_read(10'd40, "R8 new value after collision");
        a_wa = 8'd11; a_wd = 32'h99887766; a_be = 4'hF; a_we = 1'b1;
        a_ra = 10'd41; a_re = 1'b1;
        @(negedge clk);
        a_we = 1'b0; a_re = 1'b0;
        check(32'(a_q), 32'hD0, "R8 concurrent different locations read");
        ref_a[11 * 32 +: 32] = 32'h99887766;
        a_read(10'd44, "R8 concurrent different locations write");
    endtask

    task automatic t_clear;
        a_read(10'd1, "R9 prime output");
        #2 clr = 1'b1;
        #2;
        check(32'(a_q), 32'h0, "R9 clear without clock edge");
        @(negedge clk);
        clr = 1'b0;
        a_ra = 10'd50; a_rs = 1'b1; a_re = 1'b1;
        @(negedge clk);
        a_re = 1'b0; a_rs = 1'b0;
        check(32'(a_q), 32'(ref_a[0 +: 8]), "R9 R6 captured address cleared");
        a_read(10'd4, "R9 contents kept");
    endtask

    task automatic t_piped;
        for (int i = 0; i < 8; i++) b_write(11'(i), 4'(i + 1), 1'b1);
        b_read(9'd0, "R1 narrow writes, wide read word 0");
        check(32'(b_q), 32'h4321, "R1 nibble order word 0");
        b_read(9'd1, "R1 wide read word 1");
        check(32'(b_q), 32'h8765, "R1 nibble order word 1");
        b_write(11'd2, 4'hF, 1'b0);
        b_read(9'd0, "R4 single enable low");
        check(32'(b_q), 32'h4321, "R4 narrow write blocked");
        b_ra = 9'd1;
        @(negedge clk);
        @(negedge clk);
        check(32'(b_q), 32'h4321, "R3 piped hold with read enable low");
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        ref_a = '0; ref_b = '0;
        clr = 1'b1;
        a_wd = '0; a_wa = '0; a_we = 1'b0; a_be = '0; a_ws = 1'b0; a_wce = 1'b1;
        a_ra = '0; a_re = 1'b0; a_rs = 1'b0; a_rce = 1'b1;
        b_wd = '0; b_wa = '0; b_we = 1'b0; b_be = '0; b_ws = 1'b0; b_wce = 1'b1;
        b_ra = '0; b_re = 1'b0; b_rs = 1'b0; b_rce = 1'b1;
        repeat (3) @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_be();
        t_wstall();
        t_rstall();
        t_enables();
        t_same();
        t_clear();
        t_piped();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule